// File: doc/BRIEF.md
# Push and Permission Matching Table

This block sits in a requesting cache controller. It pairs a cache line pushed early by the node that last held a lock with the exclusive coherence permission for the same line, which arrives separately. Each line gets exactly one push and exactly one permission, and they may arrive in either order. The table keeps whichever half arrives first in a fully associative entry. When the second half arrives, the block decides what happens to the line and frees the entry. The line is installed as writable, or its data is discarded, or the permission is refused.

A push that cannot be placed without evicting a valid line is refused. The permission for that line is then refused as well, at once if it is already held, or when it arrives. A permission answered with a NACK causes the paired pushed data to be thrown away. The block also tells the sender how many lines it can take. Each time the controller issues a low-priority exclusive request, it reads a credit count: free entries minus entries already promised to earlier requests, never less than zero.

Messages arrive on one stream, at most one per cycle. The results are registered and appear on the cycle after the message.

Top module: `push_perm_matcher`

## Requirements
- R1: After reset no entry is held, all result outputs are low and `credit_o` equals ENTRIES.
- R2: A push (kind 0) with `msg_fits_i`=1, followed later by a grant (kind 1) for the same address, raises `install_o` on the cycle after the grant and frees the entry.
- R3: A grant held before the push of the same line raises `install_o` on the cycle after the push and frees the entry.
- R4: A push with `msg_fits_i`=0 and no held permission raises `drop_o` and keeps a refusal mark. The later permission for that line raises `reject_o` and frees the entry.
- R5: A push with `msg_fits_i`=0 that finds its permission already held raises `drop_o` and `reject_o` together, and frees the entry.
- R6: A NACK (kind 2) paired with a placed push raises `drop_o` and not `install_o`, whichever half arrived first.
- R7: `credit_o` is the count of free entries minus the outstanding promises, floored at zero. A pulse on `req_i` adds one promise only if that leaves a free entry unpromised. Each new entry allocation retires one promise.
- R8: An arrival that matches no entry while all entries are used raises `proto_err_o`. An unplaced push then raises `drop_o` and an unplaced permission raises `reject_o`. An arrival that matches an entry is still handled normally when the table is full.
- R9: A second push, or a second permission, for a line whose entry already holds that half raises `proto_err_o`. The duplicate push is dropped and the duplicate permission is rejected. The held entry is kept.
- R10: Each result (`install_o`, `drop_o`, `reject_o`, `proto_err_o`) lasts one cycle, on the cycle after the message, with `res_addr_o` equal to the message address. `install_o` never coincides with `drop_o` or `reject_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid_i | input | 1 | A message is present this cycle |
| msg_kind_i | input | 2 | 0 push, 1 grant, 2 NACK, 3 ignored |
| msg_addr_i | input | ADDR_W | Line address of the message |
| msg_fits_i | input | 1 | Push can be placed without evicting a valid line |
| req_i | input | 1 | A low-priority exclusive request is being issued |
| install_o | output | 1 | Line at res_addr_o installed writable |
| drop_o | output | 1 | Pushed data for res_addr_o discarded |
| reject_o | output | 1 | Permission for res_addr_o refused |
| res_addr_o | output | ADDR_W | Address the result refers to |
| proto_err_o | output | 1 | Unplaceable or duplicate arrival seen |
| credit_o | output | $clog2(ENTRIES+1) | Lines the table can still promise to track |

## Verification
Assertions run on every cycle. They check that no two entries hold the same address, that no entry keeps both halves past the cycle that matched them, that an entry is never loaded and freed at once, that promises never exceed free entries, and that an install never comes with a drop or a refusal. The scenarios alone show the pairing outcomes in both orders: refusal carried forward to a late permission, NACK discards, and duplicate and full-table errors. They also show that the credit count moves as requests and allocations add and retire promises, including the floor at zero.

// File: rtl/ppm_pkg.sv
// Shared types for the push/permission matching table.
// Assumes: message kinds are 2 bits; entry flags are packed for storage.
package ppm_pkg;

    typedef enum logic [1:0] {
        MSG_PUSH  = 2'd0,
        MSG_GRANT = 2'd1,
        MSG_NACK  = 2'd2,
        MSG_RSVD  = 2'd3
    } msg_kind_e;

    typedef struct packed {
        logic used;       // entry occupied
        logic has_push;   // pushed line recorded
        logic has_perm;   // permission recorded
        logic perm_nack;  // recorded permission was a NACK
        logic refused;    // push was refused; permission must be refused too
    } ent_flags_t;

endpackage

// File: rtl/ppm_entry.sv
// One tracking slot: line address plus its flag set.
// Assumes: load and clear are never requested together for one slot.
module ppm_entry
    import ppm_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  ent_flags_t        load_flags_i,
    input  logic              clear_i,
    output ent_flags_t        flags_o,
    output logic [ADDR_W-1:0] addr_o
);

    ent_flags_t        flags_q;
    logic [ADDR_W-1:0] addr_q;

    // Slot state: fill on load, empty on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            addr_q  <= '0;
        end else if (load_i) begin
            flags_q <= load_flags_i;
            addr_q  <= load_addr_i;
        end else if (clear_i) begin
            flags_q <= '0;
        end
    end

    assign flags_o = flags_q;
    assign addr_o  = addr_q;

    // A matched pair must have been freed; both halves never stay resident.
    assert_no_both_halves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flags_q.used |-> !(flags_q.has_push && flags_q.has_perm));

    // Loading and freeing one slot in the same cycle is a control fault.
    assert_no_load_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && clear_i));

endmodule

// File: rtl/ppm_lookup.sv
// Associative search: finds the slot holding a key, the lowest free slot,
// and the count of free slots.
// Assumes: at most one used slot carries a given address.
module ppm_lookup #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 40,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             used_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0]              key_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o,
    output logic                           free_any_o,
    output logic [IDX_W-1:0]               free_idx_o,
    output logic [CNT_W-1:0]               free_cnt_o
);

    logic [ENTRIES-1:0] match;

    // One comparator per slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = used_i[g] && (addr_i[g] == key_i);
    end

    // Encode the hit slot.
    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx_o = IDX_W'(i);
        end
    end
    assign hit_o = |match;

    // Lowest-index free slot and free-slot count.
    always_comb begin
        free_idx_o = '0;
        free_cnt_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!used_i[i]) begin
                free_idx_o = IDX_W'(i);
                free_cnt_o = free_cnt_o + 1'b1;
            end
        end
    end
    assign free_any_o = ~&used_i;

    // Addresses in the table stay unique.
    assert_unique_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/ppm_credit.sv
// Promise counter and advertised capacity.
// Assumes: free_next_i is the free count after this cycle's alloc/free.
module ppm_credit #(
    parameter int ENTRIES = 8,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] free_cnt_i,
    input  logic [CNT_W-1:0] free_next_i,
    input  logic             alloc_i,
    input  logic             req_i,
    output logic [CNT_W-1:0] credit_o
);

    logic [CNT_W-1:0] promised_q;
    logic [CNT_W-1:0] promised_mid;
    logic [CNT_W-1:0] avail_next;
    logic             retire;
    logic             accept;

    // Retire one promise per allocation, then grant a new one if room remains.
    always_comb begin
        retire       = alloc_i && (promised_q != '0);
        promised_mid = promised_q - CNT_W'(retire);
        avail_next   = (free_next_i > promised_mid) ? (free_next_i - promised_mid) : '0;
        accept       = req_i && (avail_next != '0);
    end

    // Promise register.
    always_ff @(posedge clk) begin
        if (!rst_n) promised_q <= '0;
        else        promised_q <= promised_mid + CNT_W'(accept);
    end

    // Advertised credit, floored at zero.
    assign credit_o = (free_cnt_i > promised_q) ? (free_cnt_i - promised_q) : '0;

    // Promises never outnumber free slots.
    assert_promise_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        promised_q <= free_cnt_i);

endmodule

// File: rtl/push_perm_matcher.sv
// Pairs speculatively pushed lines with their exclusive permissions.
// Either half may arrive first; the other completes the pair and frees the
// slot. Results are registered, one cycle after the message.
// Assumes: at most one message per cycle; one push and one permission per line.
module push_perm_matcher
    import ppm_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 40,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid_i,
    input  logic [1:0]        msg_kind_i,
    input  logic [ADDR_W-1:0] msg_addr_i,
    input  logic              msg_fits_i,
    input  logic              req_i,
    output logic              install_o,
    output logic              drop_o,
    output logic              reject_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic              proto_err_o,
    output logic [CNT_W-1:0]  credit_o
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    ent_flags_t [ENTRIES-1:0]             ent_flags;
    logic       [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic       [ENTRIES-1:0]             ent_used;

    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [CNT_W-1:0] free_cnt;
    logic [CNT_W-1:0] free_next;

    ent_flags_t hit_flags;
    ent_flags_t new_flags;
    logic       do_alloc;
    logic       do_clear;
    logic       res_install;
    logic       res_drop;
    logic       res_reject;
    logic       res_err;
    msg_kind_e  kind;

    // Used vector for the search.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_used
        assign ent_used[g] = ent_flags[g].used;
    end

    ppm_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) lookup_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .used_i     (ent_used),
        .addr_i     (ent_addr),
        .key_i      (msg_addr_i),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .free_any_o (free_any),
        .free_idx_o (free_idx),
        .free_cnt_o (free_cnt)
    );

    assign kind      = msg_kind_e'(msg_kind_i);
    assign hit_flags = ent_flags[hit_idx];

    // Pairing decision for the incoming message.
    always_comb begin
        do_alloc    = 1'b0;
        do_clear    = 1'b0;
        new_flags   = '0;
        res_install = 1'b0;
        res_drop    = 1'b0;
        res_reject  = 1'b0;
        res_err     = 1'b0;
        if (msg_valid_i) begin
            unique case (kind)
                MSG_PUSH: begin
                    if (hit && hit_flags.has_perm) begin
                        do_clear = 1'b1;
                        if (!msg_fits_i) begin
                            res_drop   = 1'b1;
                            res_reject = 1'b1;
                        end else if (hit_flags.perm_nack) begin
                            res_drop = 1'b1;
                        end else begin
                            res_install = 1'b1;
                        end
                    end else if (hit) begin
                        res_err  = 1'b1;
                        res_drop = 1'b1;
                    end else if (free_any) begin
                        do_alloc           = 1'b1;
                        new_flags.used     = 1'b1;
                        new_flags.has_push = 1'b1;
                        new_flags.refused  = !msg_fits_i;
                        res_drop           = !msg_fits_i;
                    end else begin
                        res_err  = 1'b1;
                        res_drop = 1'b1;
                    end
                end
                MSG_GRANT, MSG_NACK: begin
                    if (hit && hit_flags.has_push) begin
                        do_clear = 1'b1;
                        if (hit_flags.refused)      res_reject  = 1'b1;
                        else if (kind == MSG_NACK)  res_drop    = 1'b1;
                        else                        res_install = 1'b1;
                    end else if (hit) begin
                        res_err    = 1'b1;
                        res_reject = 1'b1;
                    end else if (free_any) begin
                        do_alloc            = 1'b1;
                        new_flags.used      = 1'b1;
                        new_flags.has_perm  = 1'b1;
                        new_flags.perm_nack = (kind == MSG_NACK);
                    end else begin
                        res_err    = 1'b1;
                        res_reject = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Slot array.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        ppm_entry #(.ADDR_W(ADDR_W)) entry_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .load_i       (do_alloc && (free_idx == IDX_W'(g))),
            .load_addr_i  (msg_addr_i),
            .load_flags_i (new_flags),
            .clear_i      (do_clear && (hit_idx == IDX_W'(g))),
            .flags_o      (ent_flags[g]),
            .addr_o       (ent_addr[g])
        );
    end

    // Free count after this cycle's update.
    assign free_next = free_cnt + CNT_W'(do_clear) - CNT_W'(do_alloc);

    ppm_credit #(.ENTRIES(ENTRIES)) credit_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .free_cnt_i  (free_cnt),
        .free_next_i (free_next),
        .alloc_i     (do_alloc),
        .req_i       (req_i),
        .credit_o    (credit_o)
    );

    // Registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            install_o   <= 1'b0;
            drop_o      <= 1'b0;
            reject_o    <= 1'b0;
            proto_err_o <= 1'b0;
            res_addr_o  <= '0;
        end else begin
            install_o   <= res_install;
            drop_o      <= res_drop;
            reject_o    <= res_reject;
            proto_err_o <= res_err;
            res_addr_o  <= msg_addr_i;
        end
    end

    // An installed line is never also dropped or refused.
    assert_install_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        install_o |-> (!drop_o && !reject_o));

    // Credit never exceeds free slots.
    assert_credit_le_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        credit_o <= free_cnt);

endmodule

// File: tb/push_perm_matcher_tb_top.sv
module push_perm_matcher_tb_top;

    localparam int ENTRIES = 4;
    localparam int ADDR_W  = 16;
    localparam int CNT_W   = $clog2(ENTRIES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msg_valid_i = 1'b0;
    logic [1:0]        msg_kind_i = 2'd0;
    logic [ADDR_W-1:0] msg_addr_i = '0;
    logic              msg_fits_i = 1'b0;
    logic              req_i = 1'b0;
    logic              install_o, drop_o, reject_o, proto_err_o;
    logic [ADDR_W-1:0] res_addr_o;
    logic [CNT_W-1:0]  credit_o;

    always #2 clk = ~clk;   // 250 MHz

    push_perm_matcher #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .msg_valid_i(msg_valid_i), .msg_kind_i(msg_kind_i),
        .msg_addr_i(msg_addr_i), .msg_fits_i(msg_fits_i), .req_i(req_i),
        .install_o(install_o), .drop_o(drop_o), .reject_o(reject_o),
        .res_addr_o(res_addr_o), .proto_err_o(proto_err_o), .credit_o(credit_o)
    );

    typedef struct packed {
        logic              inst;
        logic              drp;
        logic              rej;
        logic              err;
        logic              chk_addr;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  credit;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    localparam logic [1:0] K_PUSH = 2'd0, K_GRANT = 2'd1, K_NACK = 2'd2;

    // Driver: apply one cycle of stimulus at the falling edge, queue expectation.
    task automatic send(input logic v, input logic [1:0] k, input logic [ADDR_W-1:0] a,
                        input logic fits, input logic rq,
                        input logic ei, input logic ed, input logic er, input logic ee,
                        input int ecred, input string tag);
        exp_t e;
        @(negedge clk);
        msg_valid_i = v; msg_kind_i = k; msg_addr_i = a; msg_fits_i = fits; req_i = rq;
        e.inst = ei; e.drp = ed; e.rej = er; e.err = ee;
        e.chk_addr = ei | ed | er | ee; e.addr = a; e.credit = CNT_W'(ecred);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        #0.5;
        msg_valid_i = 1'b0; req_i = 1'b0;
    endtask

    // Monitor: one cycle after each queued message, compare the outputs.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            logic [4+ADDR_W+CNT_W-1:0] act, want;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            act  = {install_o, drop_o, reject_o, proto_err_o,
                    e.chk_addr ? res_addr_o : e.addr, credit_o};
            want = {e.inst, e.drp, e.rej, e.err, e.addr, e.credit};
            if (act !== want) begin
                n_fail++;
                $display("FAIL %s: actual inst/drop/rej/err=%b%b%b%b addr=%h credit=%0d expected %b%b%b%b addr=%h credit=%0d",
                         t, install_o, drop_o, reject_o, proto_err_o, res_addr_o, credit_o,
                         e.inst, e.drp, e.rej, e.err, e.addr, e.credit);
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if ({install_o, drop_o, reject_o, proto_err_o} !== 4'b0 || credit_o !== CNT_W'(ENTRIES)) begin
            n_fail++;
            $display("FAIL R1: actual outs=%b%b%b%b credit=%0d expected 0000 credit=%0d",
                     install_o, drop_o, reject_o, proto_err_o, credit_o, ENTRIES);
        end
        // R2: push then grant
        send(1, K_PUSH,  16'h0A01, 1, 0, 0,0,0,0, 3, "R2 push first");
        send(1, K_GRANT, 16'h0A01, 0, 0, 1,0,0,0, 4, "R2 grant completes R10");
        // R3: grant then push
        send(1, K_GRANT, 16'h0A02, 0, 0, 0,0,0,0, 3, "R3 grant first");
        send(1, K_PUSH,  16'h0A02, 1, 0, 1,0,0,0, 4, "R3 push completes");
        // R4: refused push, later permission refused
        send(1, K_PUSH,  16'h0A03, 0, 0, 0,1,0,0, 3, "R4 refused push");
        send(1, K_GRANT, 16'h0A03, 0, 0, 0,0,1,0, 4, "R4 permission refused");
        // R5: permission held, push refused
        send(1, K_GRANT, 16'h0A04, 0, 0, 0,0,0,0, 3, "R5 grant held");
        send(1, K_PUSH,  16'h0A04, 0, 0, 0,1,1,0, 4, "R5 drop and reject");
        // R6: NACK in both orders
        send(1, K_PUSH,  16'h0A05, 1, 0, 0,0,0,0, 3, "R6 push before nack");
        send(1, K_NACK,  16'h0A05, 0, 0, 0,1,0,0, 4, "R6 nack discards");
        send(1, K_NACK,  16'h0A06, 0, 0, 0,0,0,0, 3, "R6 nack first");
        send(1, K_PUSH,  16'h0A06, 1, 0, 0,1,0,0, 4, "R6 push after nack");
        // R9: duplicate halves
        send(1, K_PUSH,  16'h0A07, 1, 0, 0,0,0,0, 3, "R9 first push");
        send(1, K_PUSH,  16'h0A07, 1, 0, 0,1,0,1, 3, "R9 duplicate push");
        send(1, K_GRANT, 16'h0A08, 0, 0, 0,0,0,0, 2, "R9 first grant");
        send(1, K_GRANT, 16'h0A08, 0, 0, 0,0,1,1, 2, "R9 duplicate grant");
        send(1, K_GRANT, 16'h0A07, 0, 0, 1,0,0,0, 3, "R9 entry kept push");
        send(1, K_PUSH,  16'h0A08, 1, 0, 1,0,0,0, 4, "R9 entry kept grant");
        // R7: promises
        send(0, K_PUSH,  16'h0000, 0, 1, 0,0,0,0, 3, "R7 promise one");
        send(0, K_PUSH,  16'h0000, 0, 1, 0,0,0,0, 2, "R7 promise two");
        send(1, K_PUSH,  16'h0B01, 1, 0, 0,0,0,0, 2, "R7 alloc retires promise");
        send(0, K_PUSH,  16'h0000, 0, 1, 0,0,0,0, 1, "R7 promise three");
        send(0, K_PUSH,  16'h0000, 0, 1, 0,0,0,0, 0, "R7 promise four");
        send(0, K_PUSH,  16'h0000, 0, 1, 0,0,0,0, 0, "R7 floor at zero");
        send(1, K_PUSH,  16'h0B02, 1, 0, 0,0,0,0, 0, "R7 fill two");
        send(1, K_PUSH,  16'h0B03, 1, 0, 0,0,0,0, 0, "R7 fill three");
        send(1, K_PUSH,  16'h0B04, 1, 0, 0,0,0,0, 0, "R7 fill four");
        // R8: full table
        send(1, K_PUSH,  16'h0C01, 1, 0, 0,1,0,1, 0, "R8 push no room");
        send(1, K_GRANT, 16'h0C02, 0, 0, 0,0,1,1, 0, "R8 grant no room");
        send(1, K_GRANT, 16'h0B01, 0, 0, 1,0,0,0, 1, "R8 match while full");
        send(1, K_GRANT, 16'h0B02, 0, 0, 1,0,0,0, 2, "R2 drain two");
        send(1, K_GRANT, 16'h0B03, 0, 0, 1,0,0,0, 3, "R2 drain three");
        send(1, K_GRANT, 16'h0B04, 0, 0, 1,0,0,0, 4, "R2 drain four");
        // R10: result pulse lasts one cycle
        send(0, K_PUSH,  16'h0000, 0, 0, 0,0,0,0, 4, "R10 pulse ends");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule